// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

A cycle-accurate behavioural model of a pipelined synchronous static RAM with a four-beat burst counter, meant to sit in a simulation or FPGA prototype in place of an external memory device. Every control input is sampled on the rising clock edge. Two address strobes start an access: one for a processor and one for a memory controller. Three chip enables qualify the strobes. An advance input then steps a two-bit counter through the other words of the aligned four-word block.

Writes use a global write input, or a byte-write enable together with four per-lane selects. Each lane is 9 bits wide. Read data comes from an output register one clock after the access address is registered. The data bus is split into a write-data input and a read-data output. A drive-enable flag takes the place of a tristate pin. That flag follows an asynchronous active-low output enable. It stays off for the first data beat after the device leaves the deselected state.

Top module: `sync_burst_sram`

## Requirements
- R1: When a strobe is honoured and the enables are active (`ce1_n` low, `ce2` high, `ce3_n` low), the device captures `addr` as the access address, and the low two bits become the burst count.
- R2: When both strobes are low, only the processor strobe is acted on. An access started by the processor strobe is a read, and the write inputs are ignored in that cycle.
- R3: `adsp_n` is ignored while `ce1_n` is high. `adsc_n` is still evaluated in that cycle.
- R4: With no honoured strobe, a selected device and `adv_n` low, the access address becomes the previous one with its low two bits incremented modulo 4. The upper bits stay fixed, so 3 wraps to 0.
- R5: With no honoured strobe, a selected device and `adv_n` high, the access repeats at the held address.
- R6: With `gw_n` low, all four lanes are written, regardless of `bwe_n` and `bw_n`.
- R7: With `gw_n` high and `bwe_n` low, each lane i with `bw_n[i]` low is written. Lane i is bits 9i+8..9i. With `bwe_n` high, `bw_n` has no effect, and the cycle is a read.
- R8: Data for a read access registered on edge k appears on `rdata` after edge k+1.
- R9: `rdata_en` is high only while `oe_n` is low and the data beat comes from a read. `oe_n` acts without a clock.
- R10: The first data beat of a read that follows the deselected state is masked: `rdata_en` stays low.
- R11: An honoured strobe with inactive enables deselects the device, and no access takes place. After reset the device is deselected, and `adv_n` alone does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Registered read data |
| rdata_en | output | 1 | Read data drive enable |

## Verification
One burst is written with the global write, including a cycle in which the global write is given partial byte selects. A byte write then wraps the burst from word 3 back to word 0. A cycle that has byte selects but no byte-write enable comes next. Reading the block back separates a lane-merge error, a wrong wrap, and a stray write.

Reads are started from the deselected state by each strobe, which shows whether the first-beat mask is applied. Paired strobe patterns with `ce1_n` high or low separate strobe priority from enable gating. Held-address and advance cycles show which way the address moved, because each word holds a distinct pattern.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int BURST_W = 2;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] cur_addr,
  output lane_mask_t    lane_we,
  output logic          proc_take,
  output logic          rd_q,
  output logic          first_q
);
  logic enables_ok, ctl_take, strobe, capture, selected, sel_next;
  logic [BURST_W-1:0] next_lo;
  lane_mask_t wr_dec;

  always_comb begin
    enables_ok = !ce1_n && ce2 && !ce3_n;
    proc_take  = !adsp_n && !ce1_n;
    ctl_take   = !adsc_n && !proc_take;
    strobe     = proc_take || ctl_take;
    capture    = strobe && enables_ok;
    sel_next   = capture || (selected && !strobe);
    next_lo    = cur_addr[BURST_W-1:0] + 1'b1;
    if (capture)     acc_addr = addr;
    else if (!adv_n) acc_addr = {cur_addr[AW-1:BURST_W], next_lo};
    else             acc_addr = cur_addr;
    if (!gw_n)       wr_dec = '1;
    else if (!bwe_n) wr_dec = ~bw_n;
    else             wr_dec = '0;
    lane_we = (sel_next && !proc_take) ? wr_dec : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      selected <= 1'b0;
      cur_addr <= '0;
      rd_q     <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      selected <= sel_next;
      if (sel_next) cur_addr <= acc_addr;
      rd_q    <= sel_next && (lane_we == '0);
      first_q <= sel_next && (lane_we == '0) && !selected;
    end
  end

  assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
    (strobe && enables_ok) |=> (cur_addr == $past(addr)) && selected);

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (selected && !strobe && !adv_n) |=>
      (cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + 1)) &&
      (cur_addr[AW-1:BURST_W] == $past(cur_addr[AW-1:BURST_W])));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (selected && !strobe && adv_n) |=> $stable(cur_addr));

  assert_deselect_R11: assert property (@(posedge clk) disable iff (rst)
    (strobe && !enables_ok) |=> !selected && !rd_q);
endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  lane_mask_t        we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      rdata[g*LANE_W +: LANE_W] <= mem[raddr];
    end
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [3:0]        bw_n,
  input  logic              oe_n,
  input  logic [35:0]       wdata,
  output logic [35:0]       rdata,
  output logic              rdata_en
);
  logic [AW-1:0] acc_addr, cur_addr;
  lane_mask_t    lane_we;
  logic          proc_take, rd_q, first_q, valid_q, mask_q;

  sbs_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .acc_addr(acc_addr), .cur_addr(cur_addr),
    .lane_we(lane_we), .proc_take(proc_take), .rd_q(rd_q), .first_q(first_q)
  );

  sbs_array #(.AW(AW)) u_array (
    .clk(clk), .we(lane_we), .waddr(acc_addr), .wdata(wdata),
    .raddr(cur_addr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      valid_q <= rd_q;
      mask_q  <= first_q;
    end
  end

  assign rdata_en = !oe_n && valid_q && !mask_q;

  assert_proc_read_R2: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n && !ce1_n) |-> (lane_we == '0));

  assert_pipe_R8: assert property (@(posedge clk) disable iff (rst)
    rd_q |=> valid_q);

  assert_oe_R9: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rdata_en);

  assert_mask_R10: assert property (@(posedge clk) disable iff (rst)
    mask_q |-> !rdata_en);
endmodule

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;
  localparam int AW = 6;
  localparam int NV = 25;

  typedef struct packed {
    logic [5:0] a;
    logic sp, sc, adv, c1, c2, c3, gw, bwe;
    logic [3:0] bw;
    logic oe;
    logic [7:0] wd;
    logic en;
    logic [7:0] ex;
  } vec_t;

  // fields: a sp sc adv c1 c2 c3 gw bwe bw oe wd | en ex (255 = merged word 8)
  localparam vec_t TBL [NV] = '{
    '{8, 1,0,1, 0,1,0, 0,1, 15, 0,   8, 0,   0},
    '{0, 1,1,0, 0,1,0, 0,1, 15, 0,   9, 0,   0},
    '{0, 1,1,0, 0,1,0, 0,0, 14, 0,  10, 0,   0},
    '{0, 1,1,0, 0,1,0, 0,1, 15, 0,  11, 0,   0},
    '{0, 1,1,0, 0,1,0, 1,0, 10, 0, 100, 0,   0},
    '{0, 1,1,0, 0,1,0, 1,1,  0, 0,  55, 0,   0},
    '{0, 1,1,0, 0,1,0, 1,1, 15, 0,   0, 1,   9},
    '{0, 1,1,0, 0,1,0, 1,1, 15, 0,   0, 1,  10},
    '{0, 1,1,0, 0,1,0, 1,1, 15, 0,   0, 1,  11},
    '{0, 1,0,1, 0,0,0, 1,1, 15, 0,   0, 1, 255},
    '{0, 1,1,1, 0,1,0, 1,1, 15, 0,   0, 0,   0},
    '{9, 0,1,1, 0,1,0, 1,1, 15, 0,   0, 0,   0},
    '{0, 1,1,0, 0,1,0, 1,1, 15, 0,   0, 0,   0},
    '{0, 1,1,0, 0,1,0, 1,1, 15, 0,   0, 1,  10},
    '{0, 1,1,0, 0,1,0, 1,1, 15, 1,   0, 0,   0},
    '{10,0,0,1, 0,1,0, 0,1, 15, 0,  77, 1, 255},
    '{0, 1,1,1, 0,1,0, 1,1, 15, 0,   0, 1,  10},
    '{0, 0,1,1, 1,1,0, 1,1, 15, 0,   0, 1,  10},
    '{0, 0,0,1, 1,1,0, 1,1, 15, 0,   0, 1,  10},
    '{0, 1,1,1, 0,1,0, 1,1, 15, 0,   0, 0,   0},
    '{9, 1,0,1, 0,1,1, 1,1, 15, 0,   0, 0,   0},
    '{11,1,0,1, 0,1,0, 1,1, 15, 0,   0, 0,   0},
    '{0, 1,1,0, 0,1,0, 1,1, 15, 0,   0, 0,   0},
    '{0, 1,1,1, 0,1,0, 1,1, 15, 0,   0, 1, 255},
    '{0, 1,1,1, 0,1,0, 1,1, 15, 0,   0, 1, 255}
  };

  logic clk = 0, rst = 1;
  logic [AW-1:0] addr = '0;
  logic adsp_n = 1, adsc_n = 1, adv_n = 1, ce1_n = 0, ce2 = 1, ce3_n = 0;
  logic gw_n = 1, bwe_n = 1, oe_n = 0;
  logic [3:0] bw_n = 4'hF;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic rdata_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_burst_sram #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .wdata(wdata),
    .rdata(rdata), .rdata_en(rdata_en)
  );

  function automatic logic [35:0] pat(input int n);
    return {9'(n + 7), 9'(n + 3), 9'(n + 130), 9'(n + 1)};
  endfunction

  // R7: lanes 0 and 2 from pattern 100, lanes 1 and 3 kept from pattern 8
  function automatic logic [35:0] merged8();
    logic [35:0] o, x;
    o = pat(8); x = pat(100);
    return {o[35:27], x[26:18], o[17:9], x[8:0]};
  endfunction

  function automatic string req_of(input int i);
    case (i)
      0, 1, 2, 3: return "R6";
      4, 5, 6: return "R7";
      7, 8, 23: return "R4";
      9, 13: return "R8";
      10, 20, 21: return "R11";
      11: return "R1";
      12, 22: return "R10";
      14: return "R9";
      15, 16: return "R2";
      17, 24: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string rq, input logic exp_en, input logic [35:0] exp_d);
    checks++;
    if (rdata_en !== exp_en) begin
      errors++;
      $display("FAIL %s rdata_en actual %b expected %b", rq, rdata_en, exp_en);
    end else if (exp_en && rdata !== exp_d) begin
      errors++;
      $display("FAIL %s rdata actual %h expected %h", rq, rdata, exp_d);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    addr = '0; adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; wdata = '0;
  endtask

  initial begin
    idle();
    rst = 1;
    step(); step();
    check("R11", 1'b0, '0);   // reset state: deselected, no drive
    rst = 0;
    for (int i = 0; i < NV; i++) begin
      addr = TBL[i].a; adsp_n = TBL[i].sp; adsc_n = TBL[i].sc; adv_n = TBL[i].adv;
      ce1_n = TBL[i].c1; ce2 = TBL[i].c2; ce3_n = TBL[i].c3;
      gw_n = TBL[i].gw; bwe_n = TBL[i].bwe; bw_n = TBL[i].bw; oe_n = TBL[i].oe;
      wdata = pat(int'(TBL[i].wd));
      step();
      check(req_of(i), TBL[i].en,
            (TBL[i].ex == 8'd255) ? merged8() : pat(int'(TBL[i].ex)));
    end
    // R9: oe_n acts without a clock edge on a valid beat
    idle();
    oe_n = 1; #1;
    check("R9", 1'b0, '0);
    oe_n = 0; #1;
    check("R9", 1'b1, merged8());
    // R11: reset mid-run deselects; advance alone does nothing
    rst = 1; step();
    check("R11", 1'b0, '0);
    rst = 0; adv_n = 0; step(); step();
    check("R11", 1'b0, '0);
    // R1: controller strobe read of word 9 after reset, first beat masked
    adv_n = 1; adsc_n = 0; addr = 6'd9; step();
    adsc_n = 1; adv_n = 0; addr = '0; step();
    check("R10", 1'b0, '0);
    adv_n = 1; step();
    check("R1", 1'b1, pat(10));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule